// File: doc/BRIEF.md
# Cache Miss-Fill and Write-Through Sequencer

This block is the control core of a small unified cache placed between a 16-bit processor and an asynchronous off-chip memory. The memory exposes one bidirectional bus that carries either an address or a data word. The processor raises an access strobe together with a write select, and the cache tag logic supplies a miss flag. From these inputs the sequencer decides whether the access completes at once or must go to memory.

A read that hits finishes in one completion cycle. A read that misses fetches the whole four-word line, and each word uses its own four-wire read handshake: request, ready, data-ready and accept. A write is always sent through to memory in two phases, first the address and then the data, and each phase uses a two-wire request/accept handshake. A write that misses first fills the line in the same way as a read miss and then performs the write. The request and accept strobes and the bus drive depend only on the state. The state code and a 2-bit word counter are exported so that the cache datapath can steer line words into its block registers.

Top module: `cacheHandshakeCtrl`

## Requirements
- R1: After reset, ctrlState is 0, wordCount is 0, and rdReq, dataAck, wrReq and accessDone are all low.
- R2: While memAccess is low in state 0, the block stays in state 0 and raises no memory strobe.
- R3: An access with memAccess high, writeEn low and missFlag low moves to state 8 on the next clock and raises no memory strobe on the way.
- R4: A read miss moves to state 1. There rdReq is high and memBus carries cpuAddr. The block holds state 1 until rdReady is high, then moves to state 2, where rdReq is low and the bus is released.
- R5: In state 2, dataReady high moves the block to state 3. In state 3 dataAck is high and the block holds there until dataReady goes low. dataAck is low in every other state.
- R6: wordCount clears to 0 when a fill starts and rises by one each time a word other than word 3 is released (state 3 with dataReady low), and the block then returns to state 1. Releasing word 3 ends the fill, so exactly four words are fetched.
- R7: A write moves to state 4, where wrReq is high and memBus carries cpuAddr. wrAccept high moves it to state 5, where wrReq is low and the address is held. wrAccept low moves it to state 6, where wrReq is high and memBus carries cpuWrData. wrAccept high moves it to state 7, where the data is held. wrAccept low then moves it to state 8.
- R8: A write miss (writeEn high, missFlag high) first performs the full four-word fill of R4 to R6. After word 3 it enters state 4 instead of state 8 and completes the write of R7.
- R9: State 8 raises accessDone for exactly one cycle and always returns to state 0.
- R10: rdReq and wrReq are never high together, and the bus is driven only in states 1, 4, 5, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| memAccess | input | 1 | Processor access strobe |
| writeEn | input | 1 | 1 = write access, 0 = read access |
| missFlag | input | 1 | Tag lookup missed for the current address |
| cpuAddr | input | 16 | Processor address |
| cpuWrData | input | 16 | Processor write data |
| rdReq | output | 1 | Read request to memory |
| rdReady | input | 1 | Memory has taken the read address |
| dataReady | input | 1 | Memory is driving a read word |
| dataAck | output | 1 | Read word accepted |
| wrReq | output | 1 | Write request (address phase, then data phase) |
| wrAccept | input | 1 | Memory has taken the current write phase |
| memBus | inout | 16 | Shared address/data bus |
| ctrlState | output | 4 | Current state code for the datapath |
| wordCount | output | 2 | Line word being loaded |
| accessDone | output | 1 | Access complete (state 8) |

## Verification
The bench holds each handshake input at its waiting level for extra cycles. A controller that advanced on a level instead of a transition would skip a word or a write phase and would show a wrong state or a wrong wordCount. The fill is followed word by word through wordCount, so an off-by-one end test shows up as three or five words being fetched, or as an early completion. The write miss drops missFlag partway through the fill, and a controller that read the flag again after the fill would end in state 8 without ever writing. The bus contents are compared in both write phases, which catches an address and data that have been swapped or that are not held while the accept is pending.

// File: rtl/cacheHsPkg.sv
package cacheHsPkg;

  typedef enum logic [3:0] {
    ST_IDLE     = 4'd0,
    ST_RDREQ    = 4'd1,
    ST_RDWAIT   = 4'd2,
    ST_RDTAKE   = 4'd3,
    ST_WRADDR   = 4'd4,
    ST_WRADDRHD = 4'd5,
    ST_WRDATA   = 4'd6,
    ST_WRDATAHD = 4'd7,
    ST_DONE     = 4'd8
  } hsState_t;

  typedef struct packed {
    logic cntClear;
    logic cntInc;
    logic busAddr;
    logic busData;
  } hsStrobe_t;

endpackage

// File: rtl/cacheHsControl.sv
module cacheHsControl
  import cacheHsPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      memAccess,
  input  logic      writeEn,
  input  logic      missFlag,
  input  logic      rdReady,
  input  logic      dataReady,
  input  logic      wrAccept,
  input  logic      lastWord,
  output hsState_t  state,
  output hsStrobe_t strobe,
  output logic      rdReq,
  output logic      dataAck,
  output logic      wrReq,
  output logic      accessDone
);

  hsState_t nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (memAccess) begin
          if (missFlag)     nextState = ST_RDREQ;
          else if (writeEn) nextState = ST_WRADDR;
          else              nextState = ST_DONE;
        end
      end
      ST_RDREQ:    if (rdReady)    nextState = ST_RDWAIT;
      ST_RDWAIT:   if (dataReady)  nextState = ST_RDTAKE;
      ST_RDTAKE: begin
        if (!dataReady) begin
          if (!lastWord)    nextState = ST_RDREQ;
          else if (writeEn) nextState = ST_WRADDR;
          else              nextState = ST_DONE;
        end
      end
      ST_WRADDR:   if (wrAccept)   nextState = ST_WRADDRHD;
      ST_WRADDRHD: if (!wrAccept)  nextState = ST_WRDATA;
      ST_WRDATA:   if (wrAccept)   nextState = ST_WRDATAHD;
      ST_WRDATAHD: if (!wrAccept)  nextState = ST_DONE;
      ST_DONE:                     nextState = ST_IDLE;
      default:                     nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.cntClear = (state == ST_IDLE) && memAccess && missFlag;
    strobe.cntInc   = (state == ST_RDTAKE) && !dataReady && !lastWord;
    strobe.busAddr  = (state == ST_RDREQ) || (state == ST_WRADDR) ||
                      (state == ST_WRADDRHD);
    strobe.busData  = (state == ST_WRDATA) || (state == ST_WRDATAHD);
  end

  assign rdReq      = (state == ST_RDREQ);
  assign dataAck    = (state == ST_RDTAKE);
  assign wrReq      = (state == ST_WRADDR) || (state == ST_WRDATA);
  assign accessDone = (state == ST_DONE);

endmodule

// File: rtl/cacheHsDatapath.sv
module cacheHsDatapath
  import cacheHsPkg::*;
#(
  parameter int BUS_W = 16,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  hsStrobe_t        strobe,
  input  logic [BUS_W-1:0] cpuAddr,
  input  logic [BUS_W-1:0] cpuWrData,
  inout  wire  [BUS_W-1:0] memBus,
  output logic [CNT_W-1:0] wordCount,
  output logic             lastWord
);

  localparam logic [CNT_W-1:0] LAST_IDX = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                wordCount <= '0;
    else if (strobe.cntClear) wordCount <= '0;
    else if (strobe.cntInc)   wordCount <= wordCount + 1'b1;
  end

  assign lastWord = (wordCount == LAST_IDX);

  assign memBus = strobe.busAddr ? cpuAddr :
                  strobe.busData ? cpuWrData : {BUS_W{1'bz}};

endmodule

// File: rtl/cacheHandshakeCtrl.sv
module cacheHandshakeCtrl
  import cacheHsPkg::*;
#(
  parameter int BUS_W = 16,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             memAccess,
  input  logic             writeEn,
  input  logic             missFlag,
  input  logic [BUS_W-1:0] cpuAddr,
  input  logic [BUS_W-1:0] cpuWrData,
  output logic             rdReq,
  input  logic             rdReady,
  input  logic             dataReady,
  output logic             dataAck,
  output logic             wrReq,
  input  logic             wrAccept,
  inout  wire  [BUS_W-1:0] memBus,
  output logic [3:0]       ctrlState,
  output logic [CNT_W-1:0] wordCount,
  output logic             accessDone
);

  hsState_t  curState;
  hsStrobe_t ctrlStrobe;
  logic      lastWord;

  cacheHsControl u_control (
    .clk        (clk),
    .rstN       (rstN),
    .memAccess  (memAccess),
    .writeEn    (writeEn),
    .missFlag   (missFlag),
    .rdReady    (rdReady),
    .dataReady  (dataReady),
    .wrAccept   (wrAccept),
    .lastWord   (lastWord),
    .state      (curState),
    .strobe     (ctrlStrobe),
    .rdReq      (rdReq),
    .dataAck    (dataAck),
    .wrReq      (wrReq),
    .accessDone (accessDone)
  );

  cacheHsDatapath #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (ctrlStrobe),
    .cpuAddr   (cpuAddr),
    .cpuWrData (cpuWrData),
    .memBus    (memBus),
    .wordCount (wordCount),
    .lastWord  (lastWord)
  );

  assign ctrlState = curState;

endmodule

// File: rtl/cacheHandshakeCheck.sv
module cacheHandshakeCheck #(
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             memAccess,
  input logic             rdReady,
  input logic             dataReady,
  input logic             rdReq,
  input logic             dataAck,
  input logic             wrReq,
  input logic [3:0]       ctrlState,
  input logic [CNT_W-1:0] wordCount,
  input logic             accessDone
);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == 4'd0 && !memAccess) |=> (ctrlState == 4'd0));

  assert_rdreq_wait_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == 4'd1 && !rdReady) |=> (ctrlState == 4'd1 && rdReq));

  assert_ack_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (dataAck && dataReady) |=> dataAck);

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (dataAck && !dataReady && wordCount != {CNT_W{1'b1}})
      |=> (wordCount == $past(wordCount) + 1'b1 && ctrlState == 4'd1));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    accessDone |=> (!accessDone && ctrlState == 4'd0));

  assert_req_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(rdReq && wrReq));

endmodule

bind cacheHandshakeCtrl cacheHandshakeCheck #(.CNT_W(CNT_W)) u_check (
  .clk        (clk),
  .rstN       (rstN),
  .memAccess  (memAccess),
  .rdReady    (rdReady),
  .dataReady  (dataReady),
  .rdReq      (rdReq),
  .dataAck    (dataAck),
  .wrReq      (wrReq),
  .ctrlState  (ctrlState),
  .wordCount  (wordCount),
  .accessDone (accessDone)
);

// File: tb/cacheHandshakeCtrl_tb.sv
`timescale 1ns/1ps
module cacheHandshakeCtrl_tb;

  localparam int BUS_W = 16;
  localparam int CNT_W = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic memAccess = 1'b0, writeEn = 1'b0, missFlag = 1'b0;
  logic [BUS_W-1:0] cpuAddr = '0, cpuWrData = '0;
  logic rdReady = 1'b0, dataReady = 1'b0, wrAccept = 1'b0;
  logic rdReq, dataAck, wrReq, accessDone;
  logic [3:0] ctrlState;
  logic [CNT_W-1:0] wordCount;
  wire  [BUS_W-1:0] memBus;
  logic tbDrive = 1'b0;
  logic [BUS_W-1:0] tbWord = '0;

  int checks = 0;
  int failures = 0;

  assign memBus = tbDrive ? tbWord : {BUS_W{1'bz}};

  always #5 clk = ~clk;

  cacheHandshakeCtrl #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .memAccess(memAccess), .writeEn(writeEn),
    .missFlag(missFlag), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .rdReq(rdReq), .rdReady(rdReady), .dataReady(dataReady),
    .dataAck(dataAck), .wrReq(wrReq), .wrAccept(wrAccept),
    .memBus(memBus), .ctrlState(ctrlState), .wordCount(wordCount),
    .accessDone(accessDone)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // strobes: {rdReq, dataAck, wrReq, accessDone}
  function automatic logic [3:0] strobes();
    return {rdReq, dataAck, wrReq, accessDone};
  endfunction

  // one fill of four words, starting from state 1 with count 0
  task automatic doFill(input string req, input logic dropMiss);
    for (int w = 0; w < 4; w++) begin
      chk(req, "fill state1", ctrlState, 4'd1);
      chk("R4", "rdReq in state1", rdReq, 1'b1);
      chk("R4", "bus addr", memBus, cpuAddr);
      chk("R6", "word index", wordCount, w[CNT_W-1:0]);
      if (dropMiss) missFlag = 1'b0;
      step();
      chk("R4", "hold without rdReady", ctrlState, 4'd1);
      rdReady = 1'b1;
      step();
      chk("R4", "state2", ctrlState, 4'd2);
      chk("R4", "rdReq low in state2", rdReq, 1'b0);
      rdReady = 1'b0;
      tbDrive = 1'b1;
      tbWord  = 16'hD000 + 16'(w);
      step();
      chk("R5", "wait dataReady", ctrlState, 4'd2);
      chk("R5", "no ack yet", dataAck, 1'b0);
      dataReady = 1'b1;
      step();
      chk("R5", "state3", ctrlState, 4'd3);
      chk("R5", "dataAck", dataAck, 1'b1);
      chk("R10", "bus released", memBus, tbWord);
      step();
      chk("R5", "hold while dataReady", dataAck, 1'b1);
      dataReady = 1'b0;
      tbDrive = 1'b0;
      step();
    end
  endtask

  task automatic testReset();
    chk("R1", "state", ctrlState, 4'd0);
    chk("R1", "count", wordCount, 2'd0);
    chk("R1", "strobes", strobes(), 4'b0000);
  endtask

  task automatic testIdle();
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R2", "idle state", ctrlState, 4'd0);
      chk("R2", "idle strobes", strobes(), 4'b0000);
    end
  endtask

  task automatic testReadHit();
    cpuAddr = 16'h1234; writeEn = 1'b0; missFlag = 1'b0; memAccess = 1'b1;
    step();
    chk("R3", "hit to state8", ctrlState, 4'd8);
    chk("R3", "hit strobes", strobes(), 4'b0001);
    memAccess = 1'b0;
    step();
    chk("R9", "back to idle", ctrlState, 4'd0);
    chk("R9", "done dropped", accessDone, 1'b0);
  endtask

  task automatic testReadMiss();
    cpuAddr = 16'hA5C4; writeEn = 1'b0; missFlag = 1'b1; memAccess = 1'b1;
    step();
    doFill("R6", 1'b0);
    chk("R6", "fill ends in state8", ctrlState, 4'd8);
    chk("R9", "accessDone", accessDone, 1'b1);
    memAccess = 1'b0; missFlag = 1'b0;
    step();
    chk("R9", "idle after done", ctrlState, 4'd0);
  endtask

  task automatic writePhases(input string req);
    chk(req, "state4", ctrlState, 4'd4);
    chk("R7", "wrReq addr phase", wrReq, 1'b1);
    chk("R7", "bus addr", memBus, cpuAddr);
    step();
    chk("R7", "hold state4", ctrlState, 4'd4);
    wrAccept = 1'b1;
    step();
    chk("R7", "state5", ctrlState, 4'd5);
    chk("R7", "wrReq low", wrReq, 1'b0);
    chk("R7", "addr held", memBus, cpuAddr);
    step();
    chk("R7", "hold state5", ctrlState, 4'd5);
    wrAccept = 1'b0;
    step();
    chk("R7", "state6", ctrlState, 4'd6);
    chk("R7", "wrReq data phase", wrReq, 1'b1);
    chk("R7", "bus data", memBus, cpuWrData);
    wrAccept = 1'b1;
    step();
    chk("R7", "state7", ctrlState, 4'd7);
    chk("R7", "data held", memBus, cpuWrData);
    chk("R10", "no req in 7", {rdReq, wrReq}, 2'b00);
    wrAccept = 1'b0;
    step();
    chk(req, "write done state8", ctrlState, 4'd8);
    chk("R9", "accessDone", accessDone, 1'b1);
    memAccess = 1'b0;
    step();
    chk("R9", "idle after write", ctrlState, 4'd0);
  endtask

  task automatic testWriteHit();
    cpuAddr = 16'h0F10; cpuWrData = 16'hBEEF;
    writeEn = 1'b1; missFlag = 1'b0; memAccess = 1'b1;
    step();
    writePhases("R7");
  endtask

  task automatic testWriteMiss();
    cpuAddr = 16'h7788; cpuWrData = 16'h4321;
    writeEn = 1'b1; missFlag = 1'b1; memAccess = 1'b1;
    step();
    doFill("R8", 1'b1);
    writePhases("R8");
    writeEn = 1'b0;
  endtask

  initial begin
    fork
      begin
        #1;
        testReset();
        #20 rstN = 1'b1;
        #1;
        testReset();
        testIdle();
        testReadHit();
        testReadMiss();
        testWriteHit();
        testWriteMiss();
        testIdle();
      end
      begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule